// File: doc/BRIEF.md
# Trigger Input Event Arbiter

This block watches four active-low push-button style trigger pins, filters contact bounce on each one, and turns accepted level changes into playback requests for a downstream sequencer. Each pin can request on its press (falling debounced level) and on its release (rising debounced level). Each of those eight edges has its own enable bit. A one-time power-on start request and an externally raised jump request join the same pool of pending events.

All pending events wait in latches. A fixed priority encoder hands them out one at a time through a valid/ready port. The producer side of that port is the arbiter. Once `ev_valid` is high, `ev_code` holds still until a cycle in which `ev_ready` is also high; that cycle completes the transfer. The sink may hold `ev_ready` low for as long as it likes, and no pending event is lost while it does. Debounce and start-up timing count pulses on `tick`, so the time base is set outside the block.

Top module: `trig_event_arbiter`

## Requirements
- R1: After reset `ev_valid` is low, both enable bytes read as 0x33 (all eight edges enabled) and the mode byte is 0xFF (long filter selected).
- R2: A debounced level changes only after the raw pin has differed from it on `LONG_TICKS` (or `SHORT_TICKS`) consecutive ticks. A shorter pulse produces no event.
- R3: Mode byte bit 4 selects the filter length: 1 selects `LONG_TICKS` and 0 selects `SHORT_TICKS`.
- R4: Enable bit positions are as follows. In byte A (`en_a_wr`), bit 0 is pin 1 press, bit 1 is pin 2 press, bit 4 is pin 1 release and bit 5 is pin 2 release. Byte B (`en_b_wr`) has the same positions for pin 5 and pin 6. Bits 7, 6, 3 and 2 are ignored.
- R5: An edge whose enable bit is 0 never becomes pending and is never delivered.
- R6: Event codes are 0 start-up, 1 pin1 press, 2 pin1 release, 3 pin2 press, 4 pin2 release, 5 pin5 press, 6 pin5 release, 7 pin6 press, 8 pin6 release and 9 jump. A lower code always wins. No code above 9 appears.
- R7: The start-up request (code 0) becomes pending exactly once, `POI_TICKS` ticks after reset.
- R8: A one-cycle `jump_req` pulse latches a jump event (code 9). It is delivered after all higher-priority pending events.
- R9: While `ev_valid` is high and `ev_ready` is low, `ev_valid` and `ev_code` hold. Each transfer carries one code, and the other pending events stay latched.
- R10: Debounce and start-up counters advance only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable for filters and start-up delay |
| trig_n | input | 4 | Raw trigger pins, idle high; index 0..3 = pins 1, 2, 5, 6 |
| en_a_wr | input | 1 | Write `wr_data` to enable byte A |
| en_b_wr | input | 1 | Write `wr_data` to enable byte B |
| mode_wr | input | 1 | Write `wr_data` to the mode byte |
| wr_data | input | 8 | Register write data |
| jump_req | input | 1 | Pulse: raise a jump event |
| ev_valid | output | 1 | A granted event code is offered |
| ev_ready | input | 1 | Sink accepts the offered code |
| ev_code | output | 4 | Granted event code |

## Verification
Several debounced edges can land in the same cycle, and a jump pulse can coincide with the sink holding back. The bench presses three pins in a single step with `ev_ready` low. It then checks that the offered code is the pin 1 press and that the code stays fixed. Next it pulses a jump and releases the sink. The delivered order must be 1, 3, 5, 9, with no code duplicated or dropped.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;
  localparam int NUM_EV = 10;
  localparam int CODE_W = 4;
  localparam int NUM_PIN = 4;

  typedef enum logic [CODE_W-1:0] {
    EV_START = 4'd0, EV_P1_DN = 4'd1, EV_P1_UP = 4'd2,
    EV_P2_DN = 4'd3, EV_P2_UP = 4'd4, EV_P5_DN = 4'd5,
    EV_P5_UP = 4'd6, EV_P6_DN = 4'd7, EV_P6_UP = 4'd8,
    EV_JUMP  = 4'd9
  } ev_code_e;

  // lowest set index wins
  function automatic logic [CODE_W-1:0] lowest_set(input logic [NUM_EV-1:0] v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (v[i]) r = CODE_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int LONG_TICKS  = 500,
  parameter int SHORT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic long_sel,
  input  logic raw_n,
  output logic fell,
  output logic rose
);
  localparam int MAXT  = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic             s1, s2, level;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit, next_cnt;

  assign limit    = long_sel ? (CNT_W+1)'(LONG_TICKS) : (CNT_W+1)'(SHORT_TICKS);
  assign next_cnt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      level <= 1'b1;
      cnt   <= '0;
      fell  <= 1'b0;
      rose  <= 1'b0;
    end else begin
      s1   <= raw_n;
      s2   <= s1;
      fell <= 1'b0;
      rose <= 1'b0;
      if (s2 == level) begin
        cnt <= '0;
      end else if (tick) begin
        if (next_cnt >= limit) begin
          level <= s2;
          cnt   <= '0;
          fell  <= ~s2;
          rose  <= s2;
        end else begin
          cnt <= next_cnt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/start_timer.sv
module start_timer #(
  parameter int POI_TICKS = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic req
);
  localparam int CNT_W = $clog2(POI_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic             done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      req  <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!done && tick) begin
        if (cnt == CNT_W'(POI_TICKS - 1)) begin
          req  <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/event_grant.sv
module event_grant
  import trig_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_vec,
  input  logic              ready,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  logic [NUM_EV-1:0] pend, clr;
  logic [CODE_W-1:0] pick;
  logic              load;

  assign load = !valid || ready;
  assign pick = lowest_set(pend);

  always_comb begin
    clr = '0;
    if (load && (|pend)) clr = NUM_EV'(1) << pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      valid <= 1'b0;
      code  <= '0;
    end else begin
      pend <= (pend & ~clr) | set_vec;
      if (load) begin
        valid <= |pend;
        code  <= pick;
      end
    end
  end
endmodule

// File: rtl/trig_event_arbiter.sv
module trig_event_arbiter
  import trig_arb_pkg::*;
#(
  parameter int LONG_TICKS  = 500,
  parameter int SHORT_TICKS = 4,
  parameter int POI_TICKS   = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [3:0]        trig_n,
  input  logic              en_a_wr,
  input  logic              en_b_wr,
  input  logic              mode_wr,
  input  logic [7:0]        wr_data,
  input  logic              jump_req,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [CODE_W-1:0] ev_code
);
  localparam logic [7:0] EN_RST   = 8'h33;
  localparam logic [7:0] MODE_RST = 8'hFF;
  localparam int         LONG_BIT = 4;

  logic [7:0]         en_a, en_b, mode;
  logic [NUM_PIN-1:0] fell, rose;
  logic               start_req;
  logic [NUM_EV-1:0]  set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a <= EN_RST;
      en_b <= EN_RST;
      mode <= MODE_RST;
    end else begin
      if (en_a_wr) en_a <= wr_data;
      if (en_b_wr) en_b <= wr_data;
      if (mode_wr) mode <= wr_data;
    end
  end

  start_timer #(.POI_TICKS(POI_TICKS)) u_start (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(start_req)
  );

  assign set_vec[0]        = start_req;
  assign set_vec[NUM_EV-1] = jump_req;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    localparam int SLOT = p % 2;
    logic [7:0] en_byte;
    assign en_byte = (p < 2) ? en_a : en_b;

    trig_debounce #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_db (
      .clk(clk), .rst_n(rst_n), .tick(tick), .long_sel(mode[LONG_BIT]),
      .raw_n(trig_n[p]), .fell(fell[p]), .rose(rose[p])
    );

    assign set_vec[1 + 2*p] = fell[p] & en_byte[SLOT];
    assign set_vec[2 + 2*p] = rose[p] & en_byte[SLOT + 4];
  end

  event_grant u_grant (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .ready(ev_ready),
    .valid(ev_valid), .code(ev_code)
  );
endmodule

// File: rtl/trig_arb_chk.sv
module trig_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [3:0] ev_code
);
  logic       start_seen;
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      age        <= '0;
    end else begin
      if (ev_valid && ev_ready && ev_code == 4'd0) start_seen <= 1'b1;
      if (age != 2'd3) age <= age + 1'b1;
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code));

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_code <= 4'd9);

  // R7
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_code == 4'd0 |-> !start_seen);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age < 2'd2 |-> !ev_valid);
endmodule

bind trig_event_arbiter trig_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .ev_code(ev_code)
);

// File: tb/test_trig_event_arbiter.sv
`timescale 1ns/1ps
module test_trig_event_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [3:0] trig_n = 4'hF;
  logic       en_a_wr = 1'b0, en_b_wr = 1'b0, mode_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       jump_req = 1'b0;
  logic       ev_valid;
  logic       ev_ready = 1'b1;
  logic [3:0] ev_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] got[$];

  always #2.5 clk = ~clk;

  trig_event_arbiter #(.LONG_TICKS(16), .SHORT_TICKS(4), .POI_TICKS(40)) i_trig_event_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_n(trig_n),
    .en_a_wr(en_a_wr), .en_b_wr(en_b_wr), .mode_wr(mode_wr), .wr_data(wr_data),
    .jump_req(jump_req), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code)
  );

  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready) got.push_back(ev_code);
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // codes packed low nibble first
  task automatic expect_events(input string rq, input int n, input logic [15:0] codes);
    check(got.size() == n, {rq, " event count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      check(got[i] == codes[4*i +: 4], {rq, " event code"}, got[i], codes[4*i +: 4]);
    got.delete();
  endtask

  task automatic write_reg(input int which, input logic [7:0] d);
    wr_data = d;
    en_a_wr = (which == 0);
    en_b_wr = (which == 1);
    mode_wr = (which == 2);
    wait_cyc(1);
    en_a_wr = 0; en_b_wr = 0; mode_wr = 0;
  endtask

  task automatic tap(input int pin, input int hold, input int gap);
    trig_n[pin] = 1'b0;
    wait_cyc(hold);
    trig_n[pin] = 1'b1;
    wait_cyc(gap);
  endtask

  task automatic t_reset();
    check(ev_valid == 1'b0, "R1 valid low after reset", ev_valid, 0);
    wait_cyc(60);
    expect_events("R7 start request", 1, 16'h0000);
    wait_cyc(100);
    expect_events("R7 start only once", 0, 16'h0);
  endtask

  task automatic t_defaults();
    tap(3, 40, 40);
    expect_events("R1 R4 default enables pin6", 2, 16'h0087);
  endtask

  task automatic t_long();
    tap(0, 8, 40);
    expect_events("R2 R3 short glitch rejected in long mode", 0, 16'h0);
    tap(0, 30, 40);
    expect_events("R2 long hold accepted", 2, 16'h0021);
  endtask

  task automatic t_short();
    write_reg(2, 8'h00);
    tap(1, 2, 15);
    expect_events("R3 glitch rejected in short mode", 0, 16'h0);
    tap(1, 12, 15);
    expect_events("R3 short filter accepts", 2, 16'h0043);
  endtask

  task automatic t_enable();
    write_reg(0, 8'h01);
    tap(0, 12, 15);
    expect_events("R4 R5 only pin1 press", 1, 16'h0001);
    write_reg(0, 8'h10);
    tap(0, 12, 15);
    expect_events("R4 R5 only pin1 release", 1, 16'h0002);
    write_reg(0, 8'hCC);
    tap(0, 12, 15);
    tap(1, 12, 15);
    expect_events("R4 R5 ignored bits enable nothing", 0, 16'h0);
    write_reg(1, 8'h20);
    tap(2, 12, 15);
    tap(3, 12, 15);
    expect_events("R4 R5 only pin6 release", 1, 16'h0008);
    write_reg(0, 8'h33);
    write_reg(1, 8'h33);
  endtask

  task automatic t_tick();
    tick = 1'b0;
    trig_n[0] = 1'b0;
    wait_cyc(40);
    expect_events("R10 no progress without tick", 0, 16'h0);
    tick = 1'b1;
    wait_cyc(15);
    trig_n[0] = 1'b1;
    wait_cyc(15);
    expect_events("R10 progress with tick", 2, 16'h0021);
  endtask

  task automatic t_prio();
    ev_ready = 1'b0;
    trig_n = 4'b1000;
    wait_cyc(15);
    check(ev_valid == 1'b1, "R9 valid offered", ev_valid, 1);
    check(ev_code == 4'd1, "R6 highest code offered", ev_code, 1);
    wait_cyc(5);
    check(ev_code == 4'd1, "R9 code held under stall", ev_code, 1);
    jump_req = 1'b1;
    wait_cyc(1);
    jump_req = 1'b0;
    wait_cyc(3);
    check(got.size() == 0, "R9 nothing taken while stalled", got.size(), 0);
    ev_ready = 1'b1;
    wait_cyc(10);
    expect_events("R6 R8 R9 priority order", 4, 16'h9531);
    ev_ready = 1'b0;
    trig_n = 4'hF;
    wait_cyc(15);
    ev_ready = 1'b1;
    wait_cyc(10);
    expect_events("R6 release order", 3, 16'h0642);
    jump_req = 1'b1;
    wait_cyc(1);
    jump_req = 1'b0;
    wait_cyc(5);
    expect_events("R8 lone jump", 1, 16'h0009);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_defaults();
    t_long();
    t_short();
    t_enable();
    t_tick();
    t_prio();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule